// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Encoder

This block turns a signed fixed-point quantity into a 32-bit single-precision floating-point word. The quantity arrives as a separate sign bit plus an unsigned magnitude with 16 integer bits and 16 fraction bits, qualified by a one-cycle valid strobe. The block locates the most significant set bit of the magnitude and derives the biased exponent from its position. It shifts the magnitude so that this bit becomes the implicit leading one, keeps the next 23 bits as the stored fraction and rounds them. The result is presented with a one-cycle done strobe.

A conversion takes two clock cycles. The first cycle registers the input together with the leading-one position. The second cycle normalises, rounds and packs the word. The output word holds its value until the next conversion completes. While a conversion is in flight, the unit accepts no new request. A valid strobe that arrives then is dropped, not queued.

Top module: `fxf_encoder`

## Requirements
- R1: The output word places the sign at bit 31, the 8-bit biased exponent at bits 30..23 and the 23-bit fraction at bits 22..0.
- R2: Bit 31 of the output equals the input sign bit (1 = negative, 0 = positive) for every input, including zero.
- R3: For a non-zero magnitude the leading one is not stored. The 23 fraction bits are the magnitude bits directly below the leading one, taken from the most significant downward, with zeros filling in when fewer than 23 such bits exist.
- R4: A leading one at magnitude bit k (0..31) produces a stored exponent of k − 16 + 127 when rounding does not carry out.
- R5: The magnitude bit one place below the 23 kept fraction bits is the round bit. When it is 1, one is added to the fraction LSB (round half up, also at exact halfway points). Bits below the round bit have no influence.
- R6: When rounding carries out of the 23-bit fraction, the stored fraction becomes all zeros and the exponent is one higher than R4 gives.
- R7: A zero magnitude produces exponent 0 and fraction 0, with the sign bit still taken from the input.
- R8: A valid strobe sampled while idle is accepted. out_done is high for exactly one cycle, two rising edges after the accepting edge, and out_word carries the result from that cycle until the next completion.
- R9: in_valid sampled during the cycle after an acceptance (while converting) is ignored: it yields no done pulse and no change to out_word.
- R10: Exact values convert without error. For example, 25.62 quantised to 16.16 (0x00199EB8) encodes to 0x41CCF5C0, which has exponent 131.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; sampled only while idle |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mag | input | 32 | Unsigned magnitude, 16 integer bits over 16 fraction bits |
| out_done | output | 1 | One-cycle pulse marking a finished conversion |
| out_word | output | 32 | Packed single-precision result |

## Verification
The bench builds the block with its default 16.16 split, so the leading one can fall at each of the 32 magnitude positions. For every position it converts a lone bit, an all-ones run below it, a pseudo-random filler and an exact halfway pattern. These inputs exercise the whole exponent range, truncation-free short magnitudes, the rounding carry at every k of 24 and above, and ties that must round up. Zero with both signs, the 25.62 example and a valid held through the busy cycle complete the sweep. Each expected value comes from integer scaling arithmetic in the bench.

// File: rtl/fxf_pkg.sv
// Package fxf_pkg
// Shared constants and types for the fixed-to-float encoder.
// Assumes the single-precision layout: 1 sign, 8 exponent, 23 fraction bits.
package fxf_pkg;

    localparam int EXP_W  = 8;
    localparam int MANT_W = 23;
    localparam int BIAS   = 127;

    // packed view of the output word, MSB first
    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] frac;
    } fp_word_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CALC = 1'b1
    } enc_state_t;

endpackage

// File: rtl/fxf_lead_one.sv
// Module fxf_lead_one
// Priority search for the most significant set bit of a vector.
// Assumes nothing about the input; pos is 0 and found is 0 when it is all zero.
module fxf_lead_one #(
    parameter int W  = 32,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [LW-1:0] pos,
    output logic          found
);

    // scan upward so the highest set bit is the last one written
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = LW'(i);
        end
    end

    // any bit set at all
    assign found = |vec;

endmodule

// File: rtl/fxf_round_pack.sv
// Module fxf_round_pack
// Normalises a magnitude whose leading one sits at bit lead, rounds the
// kept fraction half up and packs sign, biased exponent and fraction.
// Assumes lead is the true leading-one position whenever nonzero is set
// and that FRAC_W does not exceed the bias.
module fxf_round_pack
    import fxf_pkg::*;
#(
    parameter int MAG_W  = 32,
    parameter int FRAC_W = 16,
    parameter int LW     = $clog2(MAG_W)
) (
    input  logic             sign,
    input  logic [MAG_W-1:0] mag,
    input  logic [LW-1:0]    lead,
    input  logic             nonzero,
    output fp_word_t         word
);

    localparam int EXT_W  = MAG_W + MANT_W + 1;
    localparam int EXP_OFS = BIAS - FRAC_W;

    logic [LW-1:0]     shamt;
    logic [MAG_W-1:0]  norm;
    logic [EXT_W-1:0]  ext;
    logic [MANT_W-1:0] kept;
    logic              rbit;
    logic [MANT_W:0]   rsum;
    logic [EXP_W:0]    exp_raw;

    // shift the leading one to the top bit
    always_comb begin
        shamt = LW'(MAG_W - 1) - lead;
        norm  = mag << shamt;
        ext   = {norm, {(MANT_W + 1){1'b0}}};
    end

    // split off kept fraction and the round bit, then round half up
    always_comb begin
        kept    = ext[EXT_W-2 -: MANT_W];
        rbit    = ext[EXT_W-2-MANT_W];
        rsum    = {1'b0, kept} + {{MANT_W{1'b0}}, rbit};
        exp_raw = (EXP_W+1)'(lead) + (EXP_W+1)'(EXP_OFS)
                + {{EXP_W{1'b0}}, rsum[MANT_W]};
    end

    // pack; a zero magnitude keeps only its sign
    always_comb begin
        word.sign = sign;
        if (nonzero) begin
            word.exp  = exp_raw[EXP_W-1:0];
            word.frac = rsum[MANT_W-1:0];
        end else begin
            word.exp  = '0;
            word.frac = '0;
        end
    end

endmodule

// File: rtl/fxf_encoder.sv
// Module fxf_encoder
// Two-cycle signed fixed-point to single-precision float converter.
// Cycle 1 registers the request and its leading-one position; cycle 2
// rounds, packs and pulses out_done. Requests arriving while busy are dropped.
// Assumes INT_W + FRAC_W <= 32 so the exponent never overflows 8 bits.
module fxf_encoder
    import fxf_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_sign,
    input  logic [INT_W+FRAC_W-1:0]   in_mag,
    output logic                      out_done,
    output logic [31:0]               out_word
);

    localparam int MAG_W = INT_W + FRAC_W;
    localparam int LW    = $clog2(MAG_W);

    enc_state_t       state_q;
    logic             sign_q;
    logic [MAG_W-1:0] mag_q;
    logic [LW-1:0]    lead_q;
    logic             nz_q;
    logic [LW-1:0]    lead_d;
    logic             nz_d;
    fp_word_t         packed_w;

    // leading-one search on the incoming magnitude
    fxf_lead_one #(.W(MAG_W), .LW(LW)) u_lead (
        .vec   (in_mag),
        .pos   (lead_d),
        .found (nz_d)
    );

    // normalise, round and pack from the stage-1 registers
    fxf_round_pack #(.MAG_W(MAG_W), .FRAC_W(FRAC_W), .LW(LW)) u_pack (
        .sign    (sign_q),
        .mag     (mag_q),
        .lead    (lead_q),
        .nonzero (nz_q),
        .word    (packed_w)
    );

    // accept in idle, complete one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sign_q   <= 1'b0;
            mag_q    <= '0;
            lead_q   <= '0;
            nz_q     <= 1'b0;
            out_done <= 1'b0;
            out_word <= '0;
        end else begin
            out_done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        sign_q  <= in_sign;
                        mag_q   <= in_mag;
                        lead_q  <= lead_d;
                        nz_q    <= nz_d;
                        state_q <= ST_CALC;
                    end
                end
                default: begin
                    out_word <= packed_w;
                    out_done <= 1'b1;
                    state_q  <= ST_IDLE;
                end
            endcase
        end
    end

    // R2: packed sign follows the captured request sign
    p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC) |=> (out_word[31] == $past(sign_q)));

    // R4: the stored position really is the top set bit
    p_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC && nz_q) |-> ((mag_q >> lead_q) == MAG_W'(1)));

    // R4: nonzero results stay within the reachable exponent window
    p_exp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_word[30:0] != 31'd0) |->
        (out_word[30:23] >= 8'(BIAS - FRAC_W) &&
         out_word[30:23] <= 8'(BIAS - FRAC_W + MAG_W)));

    // R7: zero magnitude yields zero exponent and fraction
    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC && !nz_q) |=> (out_word[30:0] == 31'd0));

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    // R8: done follows a valid request two edges earlier
    p_done_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid, 2));

endmodule

// File: tb/fxf_encoder_bench.sv
`timescale 1ns/1ps
// Bench for fxf_encoder: sweeps every leading-one position with several
// fill patterns and compares against integer-scaled expected words.
module fxf_encoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [31:0] in_mag = '0;
    logic        out_done;
    logic [31:0] out_word;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fxf_encoder u_fxf_encoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sign  (in_sign),
        .in_mag   (in_mag),
        .out_done (out_done),
        .out_word (out_word)
    );

    // expected word: scale to 24 fraction bits, round half up, renormalise
    function automatic logic [31:0] model(input logic s, input logic [31:0] m);
        int e;
        logic [63:0] t;
        logic [63:0] r;
        if (m == 32'd0) return {s, 31'd0};
        e = -16;
        while ((64'(m) >> (e + 17)) != 64'd0) e++;
        t = (64'(m) << 24) >> (e + 16);
        r = (t + 64'd1) >> 1;
        if (r == 64'd1 << 24) begin
            e++;
            r = 64'd1 << 23;
        end
        return {s, 8'(e + 127), 23'(r - (64'd1 << 23))};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // one conversion with full handshake timing checks
    task automatic convert(input string req, input logic s, input logic [31:0] m);
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_mag = m;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({"R8 no early done ", req}, 32'(out_done), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check({"R8 done ", req}, 32'(out_done), 32'd1);
        check(req, out_word, model(s, m));
        @(posedge clk);
        @(negedge clk);
        check({"R8 single pulse ", req}, 32'(out_done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        lcg = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset done", 32'(out_done), 32'd0);
        check("R1 reset word", out_word, 32'd0);
        rst_n = 1'b1;

        // R7 zero with both signs, R2 sign kept
        convert("R7 zero pos", 1'b0, 32'd0);
        convert("R7 R2 zero neg", 1'b1, 32'd0);

        // R10 exact value, also against a literal
        convert("R10 25.62", 1'b0, 32'h0019_9EB8);
        check("R10 literal", out_word, 32'h41CC_F5C0);
        convert("R10 one", 1'b0, 32'h0001_0000);
        check("R10 one literal", out_word, 32'h3F80_0000);

        for (int k = 0; k < 32; k++) begin
            logic [63:0] top;
            logic [31:0] low;
            top = 64'd1 << k;
            // R4 lone bit, R2 sign alternates
            convert("R4 R2 lone bit", k[0], 32'(top));
            // R3 R6 all ones below leading bit (carry when k >= 24)
            convert("R3 R6 ones run", ~k[0], 32'((top << 1) - 64'd1));
            // R3 R5 pseudo-random filler
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            low = lcg & 32'(top - 64'd1);
            convert("R3 R5 filler", k[1], 32'(top) | low);
            // R5 exact halfway tie rounds up
            if (k >= 24) convert("R5 tie", 1'b0, 32'(top) | (32'd1 << (k - 24)));
        end

        // R6 explicit literal: 0xFFFFFF80 rounds to 2^16 exactly
        convert("R6 carry", 1'b1, 32'hFFFF_FF80);
        check("R6 carry literal", out_word, 32'hC780_0000);

        // R9 valid held through the busy cycle with a different request
        @(negedge clk);
        in_valid = 1'b1; in_sign = 1'b0; in_mag = 32'h0003_0000;
        @(posedge clk);
        @(negedge clk);
        in_sign = 1'b1; in_mag = 32'h0000_0001;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 first done", 32'(out_done), 32'd1);
        check("R9 first word", out_word, model(1'b0, 32'h0003_0000));
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            check("R9 no done for ignored valid", 32'(out_done), 32'd0);
            check("R9 word unchanged", out_word, model(1'b0, 32'h0003_0000));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule